// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the bookkeeping side of a set-associative cache. It stores no data. For every line it keeps a valid bit, a dirty bit, a pinned bit, the full block number as the tag, and a 64-bit time of last use. A requester offers one line-aligned block number and a read/write flag. One cycle later the block reports a hit or a miss. On a miss it also reports whether the access went around the cache, and whether a fill from backing memory is called for. Seven saturating event counters record how the traffic behaved.

Replacement does not use per-set LRU bits. It compares the stored use times, which come from a free-running cycle count that the surrounding system supplies. Lines can be pinned through a dedicated port, and a pinned line is never evicted. If every way of the addressed set is valid and pinned, a miss replaces nothing and is counted as a read-around or a write-around. Line count, way count (0 selects full associativity), line size, timestamp width and counter width are parameters. The line count, way count and line size must be powers of two, and the line size must be at least 4 bytes; elaboration stops otherwise. The write-allocate policy is a configuration input.

The control is a two-state machine:
- `S_IDLE` raises `req_ready`. The transition *accept* moves to `S_RESP` when `req_valid` is high, and the request is registered.
- `S_RESP` presents the result and updates the line state. The transition *retire* always returns to `S_IDLE`.

Top module: `tag_directory`

## Requirements
- R1: `req_ready` is high only in the idle state. A request accepted on a clock edge gives `rsp_valid` high for exactly the following cycle, with `req_ready` low during that cycle.
- R2: A block maps to set `blk mod SETS`, where `SETS = LINES / WAYS`. That set's ways occupy consecutive line entries starting at `set * WAYS`. Blocks with different set bits never evict each other.
- R3: A hit requires a valid line whose stored tag equals the whole block number. A hit loads the line's use time with `now_cycle`, so the line is protected from the next eviction in its set.
- R4: The victim is the lowest-numbered invalid way of the set, if there is one. Otherwise it is the unpinned way with the strictly smallest use time. A pinned way is never a victim.
- R5: A refilled line becomes valid, holds the new tag, is clean and unpinned, and takes `now_cycle` as its use time.
- R6: A miss in a set whose ways are all valid and pinned raises `rsp_around` and leaves the set unchanged. It increments the read-around or the write-around counter, according to `req_write`.
- R7: A write hit marks the line dirty. Evicting a line that is valid and dirty increments the writeback counter.
- R8: `rsp_fill` is high for a read miss that found a victim. For a write miss that found a victim it is high only when `cfg_wr_alloc` is 1. A write miss replaces a line even when `cfg_wr_alloc` is 0.
- R9: Each response increments exactly one of read-hit, read-miss, write-hit or write-miss. An around access counts as a miss as well.
- R10: Counters saturate at all ones. Reset clears every counter and every valid bit.
- R11: Pulsing `pin_en` in the idle state pins the line that currently holds `pin_blk`, if that line is present.
- R12: `WAYS_P = 0` builds one set with `LINES` ways, so any `LINES` distinct blocks can be resident together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_alloc | input | 1 | Write-allocate policy: 1 requests a fill on a write miss |
| now_cycle | input | TS_W | Free-running cycle count used as the use time |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if `req_valid` is high |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_blk | input | BLK_W | Line-aligned block number |
| pin_en | input | 1 | Pin the line holding `pin_blk` |
| pin_blk | input | BLK_W | Block number to pin |
| rsp_valid | output | 1 | Result valid this cycle |
| rsp_hit | output | 1 | Access hit |
| rsp_miss | output | 1 | Access missed |
| rsp_around | output | 1 | Miss with no replaceable way |
| rsp_fill | output | 1 | Fill from backing memory requested |
| cnt_rd_hit | output | CNT_W | Read hits |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_hit | output | CNT_W | Write hits |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_wb | output | CNT_W | Dirty lines evicted |
| cnt_rd_around | output | CNT_W | Reads that went around |
| cnt_wr_around | output | CNT_W | Writes that went around |

## Verification
The main instance is built with 8 lines in 2 ways, which gives 4 sets with two ways each, and with 3-bit counters. With two ways per set, a third block in a set forces an eviction decided by use time. With 3-bit counters, saturation is reached within a few dozen requests. A second instance shares the same stimulus and is built fully associative with 4 lines. Four blocks that would thrash a single set of the main instance all stay resident in it together.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } dir_state_t;

    localparam int EV_RD_HIT    = 0;
    localparam int EV_RD_MISS   = 1;
    localparam int EV_WR_HIT    = 2;
    localparam int EV_WR_MISS   = 3;
    localparam int EV_WB        = 4;
    localparam int EV_RD_AROUND = 5;
    localparam int EV_WR_AROUND = 6;
    localparam int NUM_EV       = 7;

endpackage

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
    parameter int WAYS  = 2,
    parameter int TS_W  = 64,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0]            pin,
    input  logic [WAYS-1:0][TS_W-1:0]  ts,
    output logic                       found,
    output logic [WAY_W-1:0]           way
);

    logic [TS_W-1:0] best;
    logic            took_free;

    always_comb begin
        found     = 1'b0;
        way       = '0;
        best      = '1;
        took_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!took_free) begin
                if (!vld[w]) begin
                    took_free = 1'b1;
                    found     = 1'b1;
                    way       = WAY_W'(w);
                end else if (!pin[w] && (ts[w] < best)) begin
                    best  = ts[w];
                    found = 1'b1;
                    way   = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/tagdir_counter.sv
module tagdir_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && !(&cnt)) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R10: a full counter stays full
    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt) |=> (&cnt));

    // R9: an event on a non-full counter adds exactly one
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !(&cnt)) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/tag_directory.sv
module tag_directory
    import tagdir_pkg::*;
#(
    parameter int BLK_W      = 16,
    parameter int LINES      = 8,
    parameter int WAYS_P     = 2,
    parameter int LINE_BYTES = 16,
    parameter int TS_W       = 64,
    parameter int CNT_W      = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_alloc,
    input  logic [TS_W-1:0]  now_cycle,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [BLK_W-1:0] req_blk,
    input  logic             pin_en,
    input  logic [BLK_W-1:0] pin_blk,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_around,
    output logic             rsp_fill,
    output logic [CNT_W-1:0] cnt_rd_hit,
    output logic [CNT_W-1:0] cnt_rd_miss,
    output logic [CNT_W-1:0] cnt_wr_hit,
    output logic [CNT_W-1:0] cnt_wr_miss,
    output logic [CNT_W-1:0] cnt_wb,
    output logic [CNT_W-1:0] cnt_rd_around,
    output logic [CNT_W-1:0] cnt_wr_around
);

    localparam int WAYS  = (WAYS_P == 0) ? LINES : WAYS_P;
    localparam int SETS  = LINES / WAYS;
    localparam int LI_W  = $clog2(LINES);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    if ((LINES & (LINES - 1)) != 0 || LINES < 2) begin : g_bad_lines
        $error("LINES must be a power of two and at least 2");
    end
    if ((WAYS & (WAYS - 1)) != 0 || WAYS > LINES) begin : g_bad_ways
        $error("way count must be a power of two not above LINES");
    end
    if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 4) begin : g_bad_line
        $error("LINE_BYTES must be a power of two of at least 4");
    end

    // line state
    logic [LINES-1:0] l_vld, l_dirty, l_pin;
    logic [BLK_W-1:0] l_tag [LINES];
    logic [TS_W-1:0]  l_ts  [LINES];

    // state machine and registered request
    dir_state_t       st, st_nx;
    logic             q_wr;
    logic [BLK_W-1:0] q_blk;
    logic [TS_W-1:0]  q_ts;

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (req_valid) st_nx = S_RESP;   // accept
            S_RESP: st_nx = S_IDLE;                  // retire
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (st == S_IDLE && req_valid) begin
            q_wr  <= req_write;
            q_blk <= req_blk;
            q_ts  <= now_cycle;
        end
    end

    // set lookup for the registered request
    logic [LI_W-1:0]             base, hidx, vidx;
    logic [WAYS-1:0]             sv_vld, sv_pin, match;
    logic [WAYS-1:0][TS_W-1:0]   sv_ts;
    logic                        hit, v_found;
    logic [WAY_W-1:0]            hit_way, v_way;

    always_comb begin
        base    = LI_W'((int'(q_blk) & (SETS - 1)) * WAYS);
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            sv_vld[w] = l_vld[base + LI_W'(w)];
            sv_pin[w] = l_pin[base + LI_W'(w)];
            sv_ts[w]  = l_ts[base + LI_W'(w)];
            match[w]  = l_vld[base + LI_W'(w)] && (l_tag[base + LI_W'(w)] == q_blk);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
        hit  = |match;
        hidx = base + LI_W'(hit_way);
        vidx = base + LI_W'(v_way);
    end

    tagdir_victim #(.WAYS(WAYS), .TS_W(TS_W), .WAY_W(WAY_W)) u_victim (
        .vld   (sv_vld),
        .pin   (sv_pin),
        .ts    (sv_ts),
        .found (v_found),
        .way   (v_way)
    );

    // pin lookup
    logic [LI_W-1:0] pbase, pidx;
    logic            pin_hit;

    always_comb begin
        pbase   = LI_W'((int'(pin_blk) & (SETS - 1)) * WAYS);
        pidx    = pbase;
        pin_hit = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!pin_hit && l_vld[pbase + LI_W'(w)] && (l_tag[pbase + LI_W'(w)] == pin_blk)) begin
                pin_hit = 1'b1;
                pidx    = pbase + LI_W'(w);
            end
        end
    end

    // outputs per state
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        rsp_hit    = 1'b0;
        rsp_miss   = 1'b0;
        rsp_around = 1'b0;
        rsp_fill   = 1'b0;
        unique case (st)
            S_IDLE: req_ready = 1'b1;
            S_RESP: begin
                rsp_valid  = 1'b1;
                rsp_hit    = hit;
                rsp_miss   = !hit;
                rsp_around = !hit && !v_found;
                rsp_fill   = !hit && v_found && (!q_wr || cfg_wr_alloc);
            end
        endcase
    end

    // line state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_vld   <= '0;
            l_dirty <= '0;
            l_pin   <= '0;
        end else if (st == S_RESP) begin
            if (hit) begin
                if (q_wr) l_dirty[hidx] <= 1'b1;
            end else if (v_found) begin
                l_vld[vidx]   <= 1'b1;
                l_dirty[vidx] <= 1'b0;
                l_pin[vidx]   <= 1'b0;
            end
        end else if (pin_en && pin_hit) begin
            l_pin[pidx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (st == S_RESP) begin
            if (hit) begin
                l_ts[hidx] <= q_ts;
            end else if (v_found) begin
                l_tag[vidx] <= q_blk;
                l_ts[vidx]  <= q_ts;
            end
        end
    end

    // event counters
    logic [NUM_EV-1:0] ev;
    logic [CNT_W-1:0]  cnt_q [NUM_EV];

    always_comb begin
        ev               = '0;
        ev[EV_RD_HIT]    = rsp_valid && hit && !q_wr;
        ev[EV_RD_MISS]   = rsp_valid && !hit && !q_wr;
        ev[EV_WR_HIT]    = rsp_valid && hit && q_wr;
        ev[EV_WR_MISS]   = rsp_valid && !hit && q_wr;
        ev[EV_WB]        = rsp_valid && !hit && v_found && l_vld[vidx] && l_dirty[vidx];
        ev[EV_RD_AROUND] = rsp_valid && !hit && !v_found && !q_wr;
        ev[EV_WR_AROUND] = rsp_valid && !hit && !v_found && q_wr;
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
        tagdir_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[g]),
            .cnt   (cnt_q[g])
        );
    end

    assign cnt_rd_hit    = cnt_q[EV_RD_HIT];
    assign cnt_rd_miss   = cnt_q[EV_RD_MISS];
    assign cnt_wr_hit    = cnt_q[EV_WR_HIT];
    assign cnt_wr_miss   = cnt_q[EV_WR_MISS];
    assign cnt_wb        = cnt_q[EV_WB];
    assign cnt_rd_around = cnt_q[EV_RD_AROUND];
    assign cnt_wr_around = cnt_q[EV_WR_AROUND];

    // assertions
    assert_resp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid && !req_ready));

    assert_resp_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_victim_unpinned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RESP && !hit && v_found) |-> !(sv_vld[v_way] && sv_pin[v_way]));

    assert_refill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RESP && !hit && v_found) |=>
            (l_vld[$past(vidx)] && !l_dirty[$past(vidx)] && !l_pin[$past(vidx)]));

    assert_around_no_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_around |-> (rsp_miss && !rsp_fill));

    assert_fill_policy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fill && q_wr) |-> cfg_wr_alloc);

endmodule

// File: tb/tag_directory_tb.sv
module tag_directory_tb;

    localparam int BLK_W = 16;
    localparam int TS_W  = 64;
    localparam int CNT_W = 3;
    localparam int CMAX  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr_alloc = 1'b1;
    logic [TS_W-1:0]  now_cycle = '0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic             pin_en = 1'b0;
    logic [BLK_W-1:0] pin_blk = '0;

    logic             req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_around, rsp_fill;
    logic [CNT_W-1:0] c_rh, c_rm, c_wh, c_wm, c_wb, c_ra, c_wa;

    logic             fa_ready, fa_valid, fa_hit, fa_miss, fa_around, fa_fill;
    logic [CNT_W-1:0] f0, f1, f2, f3, f4, f5, f6;

    always #5 clk = ~clk;

    tag_directory #(.BLK_W(BLK_W), .LINES(8), .WAYS_P(2), .TS_W(TS_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_alloc(cfg_wr_alloc), .now_cycle(now_cycle),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_blk(req_blk),
        .pin_en(pin_en), .pin_blk(pin_blk),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_around(rsp_around), .rsp_fill(rsp_fill),
        .cnt_rd_hit(c_rh), .cnt_rd_miss(c_rm), .cnt_wr_hit(c_wh), .cnt_wr_miss(c_wm),
        .cnt_wb(c_wb), .cnt_rd_around(c_ra), .cnt_wr_around(c_wa)
    );

    tag_directory #(.BLK_W(BLK_W), .LINES(4), .WAYS_P(0), .TS_W(TS_W), .CNT_W(CNT_W)) u_dut_fa (
        .clk(clk), .rst_n(rst_n), .cfg_wr_alloc(cfg_wr_alloc), .now_cycle(now_cycle),
        .req_valid(req_valid), .req_ready(fa_ready), .req_write(req_write), .req_blk(req_blk),
        .pin_en(pin_en), .pin_blk(pin_blk),
        .rsp_valid(fa_valid), .rsp_hit(fa_hit), .rsp_miss(fa_miss),
        .rsp_around(fa_around), .rsp_fill(fa_fill),
        .cnt_rd_hit(f0), .cnt_rd_miss(f1), .cnt_wr_hit(f2), .cnt_wr_miss(f3),
        .cnt_wb(f4), .cnt_rd_around(f5), .cnt_wr_around(f6)
    );

    int n_chk = 0;
    int n_fail = 0;
    int e_rh, e_rm, e_wh, e_wm, e_wb, e_ra, e_wa;
    logic last_fa_hit;

    typedef struct packed {
        logic        wr;
        logic [15:0] blk;
        logic [15:0] ts;
        logic        hit;
        logic        fill;
        logic        wb;
    } vec_t;

    // two-way sets; set = blk mod 4
    localparam vec_t VEC [8] = '{
        '{1'b0, 16'h0010, 16'd1, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'h0010, 16'd2, 1'b1, 1'b0, 1'b0},
        '{1'b0, 16'h0020, 16'd3, 1'b0, 1'b1, 1'b0},
        '{1'b1, 16'h0010, 16'd4, 1'b1, 1'b0, 1'b0},
        '{1'b0, 16'h0030, 16'd5, 1'b0, 1'b1, 1'b0},
        '{1'b0, 16'h0020, 16'd6, 1'b0, 1'b1, 1'b1},
        '{1'b0, 16'h0030, 16'd7, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'h0041, 16'd8, 1'b0, 1'b1, 1'b0}
    };

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_counters(input string req);
        chk(c_rh == CNT_W'(e_rh), {req, " R9 rd_hit"},    c_rh, e_rh);
        chk(c_rm == CNT_W'(e_rm), {req, " R9 rd_miss"},   c_rm, e_rm);
        chk(c_wh == CNT_W'(e_wh), {req, " R9 wr_hit"},    c_wh, e_wh);
        chk(c_wm == CNT_W'(e_wm), {req, " R9 wr_miss"},   c_wm, e_wm);
        chk(c_wb == CNT_W'(e_wb), {req, " R7 wb"},        c_wb, e_wb);
        chk(c_ra == CNT_W'(e_ra), {req, " R6 rd_around"}, c_ra, e_ra);
        chk(c_wa == CNT_W'(e_wa), {req, " R6 wr_around"}, c_wa, e_wa);
    endtask

    // call and return at a falling edge in the idle state
    task automatic do_req(input bit wr, input int blk, input int ts,
                          input bit x_hit, input bit x_around, input bit x_fill,
                          input bit x_wb, input string req);
        req_valid = 1'b1;
        req_write = wr;
        req_blk   = BLK_W'(blk);
        now_cycle = TS_W'(ts);
        chk(req_ready == 1'b1, {req, " R1 ready idle"}, req_ready, 1);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1,     {req, " R1 rsp_valid"}, rsp_valid, 1);
        chk(req_ready == 1'b0,     {req, " R1 busy"},      req_ready, 0);
        chk(rsp_hit == x_hit,      {req, " hit"},          rsp_hit, x_hit);
        chk(rsp_miss == !x_hit,    {req, " miss"},         rsp_miss, !x_hit);
        chk(rsp_around == x_around,{req, " around"},       rsp_around, x_around);
        chk(rsp_fill == x_fill,    {req, " fill"},         rsp_fill, x_fill);
        last_fa_hit = fa_hit;
        req_valid = 1'b0;
        if (x_hit) begin
            if (wr) e_wh = sat(e_wh); else e_rh = sat(e_rh);
        end else begin
            if (wr) e_wm = sat(e_wm); else e_rm = sat(e_rm);
            if (x_around) begin
                if (wr) e_wa = sat(e_wa); else e_ra = sat(e_ra);
            end
        end
        if (x_wb) e_wb = sat(e_wb);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, {req, " R1 one cycle"}, rsp_valid, 0);
        chk_counters(req);
    endtask

    task automatic do_pin(input int blk);
        pin_en  = 1'b1;
        pin_blk = BLK_W'(blk);
        @(posedge clk);
        @(negedge clk);
        pin_en  = 1'b0;
    endtask

    task automatic clear_model();
        e_rh = 0; e_rm = 0; e_wh = 0; e_wm = 0; e_wb = 0; e_ra = 0; e_wa = 0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state R10
        chk(req_ready == 1'b1, "R10 reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R10 reset rsp_valid", rsp_valid, 0);
        chk_counters("R10 reset");

        // table: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < 8; i++) begin
            do_req(VEC[i].wr, int'(VEC[i].blk), int'(VEC[i].ts), VEC[i].hit, 1'b0,
                   VEC[i].fill, VEC[i].wb, $sformatf("R4 vec%0d", i));
        end

        // R8: write miss without allocate still replaces
        cfg_wr_alloc = 1'b0;
        do_req(1'b1, 'h42, 20, 1'b0, 1'b0, 1'b0, 1'b0, "R8 wr no-alloc");
        do_req(1'b0, 'h42, 21, 1'b1, 1'b0, 1'b0, 1'b0, "R8 replaced");
        cfg_wr_alloc = 1'b1;

        // R6 R11: fully pinned set goes around
        do_pin('h20);
        do_pin('h30);
        do_req(1'b0, 'h50, 30, 1'b0, 1'b1, 1'b0, 1'b0, "R6 rd around");
        do_req(1'b0, 'h20, 31, 1'b1, 1'b0, 1'b0, 1'b0, "R6 set kept");
        do_req(1'b1, 'h60, 32, 1'b0, 1'b1, 1'b0, 1'b0, "R6 wr around");
        do_req(1'b0, 'h30, 33, 1'b1, 1'b0, 1'b0, 1'b0, "R11 pinned kept");

        // R4 R11: pinned older line skipped
        do_req(1'b0, 'h03, 40, 1'b0, 1'b0, 1'b1, 1'b0, "R4 fill w0");
        do_req(1'b0, 'h07, 41, 1'b0, 1'b0, 1'b1, 1'b0, "R4 fill w1");
        do_pin('h03);
        do_req(1'b0, 'h0B, 42, 1'b0, 1'b0, 1'b1, 1'b0, "R11 evict unpinned");
        do_req(1'b0, 'h03, 43, 1'b1, 1'b0, 1'b0, 1'b0, "R11 pinned stays");
        do_req(1'b0, 'h07, 44, 1'b0, 1'b0, 1'b1, 1'b0, "R4 evict other");

        // R3: hit refreshes use time
        do_req(1'b0, 'h02, 50, 1'b0, 1'b0, 1'b1, 1'b0, "R3 fill");
        do_req(1'b0, 'h42, 51, 1'b1, 1'b0, 1'b0, 1'b0, "R3 refresh");
        do_req(1'b0, 'h06, 52, 1'b0, 1'b0, 1'b1, 1'b0, "R3 evict older");
        do_req(1'b0, 'h42, 53, 1'b1, 1'b0, 1'b0, 1'b0, "R3 refreshed kept");
        do_req(1'b0, 'h02, 54, 1'b0, 1'b0, 1'b1, 1'b0, "R3 evicted gone");

        // R7: dirty eviction
        do_req(1'b1, 'h42, 55, 1'b1, 1'b0, 1'b0, 1'b0, "R7 wr hit");
        do_req(1'b0, 'h0E, 56, 1'b0, 1'b0, 1'b1, 1'b0, "R7 clean evict");
        do_req(1'b0, 'h12, 57, 1'b0, 1'b0, 1'b1, 1'b1, "R7 dirty evict");

        // R10: saturation reached
        chk(c_rh == CNT_W'(CMAX), "R10 saturate rd_hit", c_rh, CMAX);
        chk(c_rm == CNT_W'(CMAX), "R10 saturate rd_miss", c_rm, CMAX);

        // R10: reset clears counters and valids
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        chk_counters("R10 after reset");
        do_req(1'b0, 'h30, 60, 1'b0, 1'b0, 1'b1, 1'b0, "R10 valids cleared");

        // R12: fully associative instance keeps four set-0 blocks
        do_req(1'b0, 'h100, 61, 1'b0, 1'b0, 1'b1, 1'b0, "R12 a");
        do_req(1'b0, 'h104, 62, 1'b0, 1'b0, 1'b1, 1'b0, "R12 b");
        do_req(1'b0, 'h108, 63, 1'b0, 1'b0, 1'b1, 1'b0, "R12 c");
        do_req(1'b0, 'h30,  64, 1'b0, 1'b0, 1'b1, 1'b0, "R2 main thrashed");
        chk(last_fa_hit == 1'b1, "R12 fully assoc hit", last_fa_hit, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule